// File: doc/BRIEF.md
# Configuration Switch Output Select, Latch and Override Unit

This unit drives the outputs of a small configuration switch. A stored configuration word of five bits arrives from a non-volatile register. The four low bits can be presented on four selectable outputs. A select line can instead route four external input lines onto those outputs. The fifth stored bit drives one auxiliary output. That output passes the stored bit through while select is low and freezes its value while select is high. An active-low override line forces every output to zero, but only while select is low. An output-enable signal from the bus interface turns off the drivers of the four selectable outputs, for example during a bus write to the stored word.

Select and override are asynchronous board-level lines. Each passes through a synchronizer chain. A three-state machine then decides the output mode:
- `ST_TRACK`: select low, override high. The outputs show the stored word.
- `ST_FORCE`: select low, override low. All outputs are zero.
- `ST_HOLD`: select high. The selectable outputs carry the external inputs, and the auxiliary output shows the frozen bit.

The state machine has these transitions:
- Any state goes to `ST_HOLD` when the synchronized select is 1.
- Any state goes to `ST_FORCE` when the synchronized select is 0 and the synchronized override is 0.
- Any state goes to `ST_TRACK` when the synchronized select is 0 and the synchronized override is 1.

The frozen bit is a register. It loads every cycle the machine is in `ST_TRACK` or `ST_FORCE`, taking the value the auxiliary output shows in that cycle. It keeps its value in `ST_HOLD`.

Top module: `cfgsw_out_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) makes the following true after reset is released: the machine is in `ST_HOLD`, the frozen auxiliary bit is 0, and both synchronizer chains read 1, which is the undriven level of select and override. So with select and override held at 1, sel_out equals ext_in and aux_out is 0.
- R2: In `ST_TRACK` (synchronized select 0, synchronized override 1), sel_out equals cfg_word[3:0] and aux_out equals cfg_word[4]. A change of cfg_word shows at the outputs in the same cycle.
- R3: While the synchronized select is 1, sel_out equals ext_in, and changes of ext_in show in the same cycle.
- R4: While the machine stays in `ST_HOLD`, aux_out does not change, whatever cfg_word does.
- R5: The frozen value is the aux_out value of the last cycle before entering `ST_HOLD`. When override was high, this is cfg_word[4] as it stood then.
- R6: In `ST_FORCE` (synchronized select 0, synchronized override 0), sel_out is 4'b0000 and aux_out is 0, whatever cfg_word holds.
- R7: While the synchronized select is 1, the override line has no effect. Both sel_out (equal to ext_in) and aux_out (the frozen bit) are the same with override at 0 and at 1.
- R8: While bus_oe is 0, all four bits of sel_out_en are 0, so the selectable drivers are off. While bus_oe is 1, all four are 1. bus_oe never changes aux_out.
- R9: A change on sel_raw or ovr_n_raw driven between two edges reaches the outputs after the third rising edge that follows: two synchronizer stages plus the state register. After the second edge, the outputs still show the old mode.
- R10: If `ST_HOLD` is entered from `ST_FORCE`, the frozen bit is 0 even when cfg_word[4] is 1. It stays 0 when override is later released while select remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 5 | Stored configuration word; bit 4 feeds the auxiliary output, bits 3:0 feed the selectable outputs |
| ext_in | input | 4 | External input lines for the selectable outputs |
| sel_raw | input | 1 | Asynchronous select: 0 picks the stored word, 1 picks ext_in and freezes the auxiliary bit |
| ovr_n_raw | input | 1 | Asynchronous override, active low; acts only while select is low |
| bus_oe | input | 1 | Output enable from the bus interface |
| sel_out | output | 4 | Selectable output data |
| sel_out_en | output | 4 | Per-bit driver enable for sel_out; 0 means high impedance |
| aux_out | output | 1 | Auxiliary output, latched under select |

## Verification
The bench builds the unit with its defaults: four selectable bits and a two-stage synchronizer. That makes the select-to-output latency a fixed three edges, which the bench can check exactly on both sides of the switch. With these values, every mode change can be placed at a known edge. This covers hold entry from `ST_TRACK` and from `ST_FORCE`, override pulses inside `ST_HOLD`, and stored-word changes after the freeze. It also makes it possible to find the exact cycle in which the frozen bit is captured.

// File: rtl/cfgsw_out_pkg.sv
package cfgsw_out_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_FORCE = 2'd1,
        ST_HOLD  = 2'd2
    } out_mode_e;
endpackage

// File: rtl/cfgsw_sync.sv
module cfgsw_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgsw_mode_fsm.sv
module cfgsw_mode_fsm
    import cfgsw_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_s,
    input  logic      ovr_n_s,
    input  logic      aux_now,
    output out_mode_e state,
    output logic      aux_hold
);
    out_mode_e state_nxt;

    always_comb begin
        if (sel_s) begin
            state_nxt = ST_HOLD;
        end else if (!ovr_n_s) begin
            state_nxt = ST_FORCE;
        end else begin
            state_nxt = ST_TRACK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    // frozen bit: loads what aux shows while not holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_hold <= 1'b0;
        end else begin
            unique case (state)
                ST_TRACK: aux_hold <= aux_now;
                ST_FORCE: aux_hold <= 1'b0;
                ST_HOLD:  aux_hold <= aux_hold;
                default:  aux_hold <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfgsw_out_mux.sv
module cfgsw_out_mux
    import cfgsw_out_pkg::*;
#(
    parameter int NSEL = 4
) (
    input  out_mode_e       state,
    input  logic [NSEL-1:0] cfg_low,
    input  logic            cfg_aux,
    input  logic [NSEL-1:0] ext_in,
    input  logic            aux_hold,
    input  logic            bus_oe,
    output logic [NSEL-1:0] sel_out,
    output logic [NSEL-1:0] sel_out_en,
    output logic            aux_out
);
    always_comb begin
        unique case (state)
            ST_TRACK: begin
                sel_out = cfg_low;
                aux_out = cfg_aux;
            end
            ST_FORCE: begin
                sel_out = '0;
                aux_out = 1'b0;
            end
            ST_HOLD: begin
                sel_out = ext_in;
                aux_out = aux_hold;
            end
            default: begin
                sel_out = '0;
                aux_out = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_en
        assign sel_out_en[i] = bus_oe;
    end
endmodule

// File: rtl/cfgsw_out_unit.sv
module cfgsw_out_unit
    import cfgsw_out_pkg::*;
#(
    parameter int NSEL        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEL:0]   cfg_word,
    input  logic [NSEL-1:0] ext_in,
    input  logic            sel_raw,
    input  logic            ovr_n_raw,
    input  logic            bus_oe,
    output logic [NSEL-1:0] sel_out,
    output logic [NSEL-1:0] sel_out_en,
    output logic            aux_out
);
    localparam int AUX_BIT = NSEL;

    logic      sel_s;
    logic      ovr_n_s;
    logic      aux_hold;
    out_mode_e mode_st;

    cfgsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_raw), .q(sel_s)
    );

    cfgsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ovr_sync (
        .clk(clk), .rst_n(rst_n), .d(ovr_n_raw), .q(ovr_n_s)
    );

    cfgsw_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .ovr_n_s  (ovr_n_s),
        .aux_now  (cfg_word[AUX_BIT]),
        .state    (mode_st),
        .aux_hold (aux_hold)
    );

    cfgsw_out_mux #(.NSEL(NSEL)) u_mux (
        .state      (mode_st),
        .cfg_low    (cfg_word[NSEL-1:0]),
        .cfg_aux    (cfg_word[AUX_BIT]),
        .ext_in     (ext_in),
        .aux_hold   (aux_hold),
        .bus_oe     (bus_oe),
        .sel_out    (sel_out),
        .sel_out_en (sel_out_en),
        .aux_out    (aux_out)
    );
endmodule

// File: rtl/cfgsw_out_unit_chk.sv
module cfgsw_out_unit_chk
    import cfgsw_out_pkg::*;
#(
    parameter int NSEL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  out_mode_e       st,
    input  logic [NSEL:0]   cfg_word,
    input  logic [NSEL-1:0] ext_in,
    input  logic            bus_oe,
    input  logic [NSEL-1:0] sel_out,
    input  logic [NSEL-1:0] sel_out_en,
    input  logic            aux_out
);
    // R2
    track_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRACK) |-> (sel_out == cfg_word[NSEL-1:0] && aux_out == cfg_word[NSEL]));

    // R3
    hold_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (sel_out == ext_in));

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> $stable(aux_out));

    // R6
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FORCE) |-> (sel_out == '0 && !aux_out));

    // R8
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (sel_out_en == '0));

    // R10
    force_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_FORCE && st == ST_HOLD) |-> !aux_out);
endmodule

bind cfgsw_out_unit cfgsw_out_unit_chk #(.NSEL(NSEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (mode_st),
    .cfg_word   (cfg_word),
    .ext_in     (ext_in),
    .bus_oe     (bus_oe),
    .sel_out    (sel_out),
    .sel_out_en (sel_out_en),
    .aux_out    (aux_out)
);

// File: tb/cfgsw_out_unit_bench.sv
module cfgsw_out_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] cfg_word;
    logic [3:0] ext_in;
    logic       sel_raw;
    logic       ovr_n_raw;
    logic       bus_oe;
    logic [3:0] sel_out;
    logic [3:0] sel_out_en;
    logic       aux_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgsw_out_unit u_cfgsw_out_unit (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ext_in(ext_in),
        .sel_raw(sel_raw), .ovr_n_raw(ovr_n_raw), .bus_oe(bus_oe),
        .sel_out(sel_out), .sel_out_en(sel_out_en), .aux_out(aux_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // compares {aux_out, sel_out}
    task automatic check_out(input string tag, input logic [4:0] exp);
        check(tag, {3'b0, aux_out, sel_out}, {3'b0, exp});
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sel_raw = 1'b1; ovr_n_raw = 1'b1; bus_oe = 1'b1;
        cfg_word = 5'b1_1001; ext_in = 4'b0110;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_out("R1 reset state", 5'b0_0110);
        @(negedge clk);
        check_out("R1 after release", 5'b0_0110);
    endtask

    task automatic t_track();
        sel_raw = 1'b0; ovr_n_raw = 1'b1;
        cfg_word = 5'b1_0110; ext_in = 4'b1001;
        settle();
        check_out("R2 track pattern a", 5'b1_0110);
        cfg_word = 5'b0_1001;
        @(negedge clk);
        check_out("R2 track pattern b", 5'b0_1001);
        cfg_word = 5'b1_1111;
        @(negedge clk);
        check_out("R2 track pattern c", 5'b1_1111);
    endtask

    task automatic t_latency();
        cfg_word = 5'b1_0101; ext_in = 4'b1010;
        @(negedge clk);
        sel_raw = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out("R9 old mode after two edges", 5'b1_0101);
        @(posedge clk);
        @(negedge clk);
        check_out("R9 new mode after third edge", 5'b1_1010);
    endtask

    task automatic t_hold();
        sel_raw = 1'b0; ovr_n_raw = 1'b1; cfg_word = 5'b1_0011; ext_in = 4'b0101;
        settle();
        sel_raw = 1'b1;
        settle();
        check_out("R5 captured stored bit", 5'b1_0101);
        cfg_word = 5'b0_1100;
        settle();
        check_out("R4 stored change ignored in hold", 5'b1_0101);
        ext_in = 4'b1110;
        @(negedge clk);
        check_out("R3 ext_in follows in hold", 5'b1_1110);
        ovr_n_raw = 1'b0;
        settle();
        check_out("R7 override low in hold", 5'b1_1110);
        ovr_n_raw = 1'b1;
        settle();
        check_out("R7 override released in hold", 5'b1_1110);
        // capture of a 0 stored bit
        sel_raw = 1'b0; cfg_word = 5'b0_1111;
        settle();
        sel_raw = 1'b1;
        settle();
        cfg_word = 5'b1_1111;
        settle();
        check_out("R5 captured zero kept", 5'b0_1110);
    endtask

    task automatic t_force();
        sel_raw = 1'b0; ovr_n_raw = 1'b0; cfg_word = 5'b1_1111; ext_in = 4'b1011;
        settle();
        check_out("R6 force zeros", 5'b0_0000);
        cfg_word = 5'b1_0110;
        @(negedge clk);
        check_out("R6 force ignores stored word", 5'b0_0000);
        sel_raw = 1'b1;
        settle();
        check_out("R10 hold entered from force", 5'b0_1011);
        ovr_n_raw = 1'b1;
        settle();
        check_out("R10 override released keeps zero", 5'b0_1011);
    endtask

    task automatic t_oe();
        sel_raw = 1'b0; ovr_n_raw = 1'b1; cfg_word = 5'b1_0010;
        settle();
        bus_oe = 1'b0;
        #1;
        check("R8 drivers off", {4'b0, sel_out_en}, 8'h00);
        check_out("R8 aux unaffected by oe", 5'b1_0010);
        bus_oe = 1'b1;
        #1;
        check("R8 drivers on", {4'b0, sel_out_en}, 8'h0F);
    endtask

    initial begin
        t_reset();
        t_track();
        t_latency();
        t_hold();
        t_force();
        t_oe();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule